// File: doc/BRIEF.md
# External Interrupt Pending and Enable Unit

This block holds one pending flag and one enable flag for each external interrupt source of a processor. Other processors and I/O modules raise an interrupt through a memory-mapped write that carries the number of a single source; the block turns that number into one set bit in the pending register. The local processor reads both registers directly. Through a control-register write it can acknowledge interrupts, but only by clearing them: each 1 in the written data clears the matching pending flag. The enable register is loaded directly by the same control-register port.

A width mode input decides how the source number is read. In wide mode it is a 6-bit number that reaches all 64 sources. In narrow mode only its low 5 bits count, and it reaches the lower half of the register. Numbers count from the most significant end, so number 0 names the top bit. The block raises a registered interrupt request when some source is both pending and enabled while the global interrupt enable is high. Choosing which source to serve and delivering the request to the core are left to other logic.

Top module: `xint_pend_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `pend_q`, `mask_q` and `irq` become all zeros.
- R2: A control-register write with `cr_sel` = 1 loads `cr_wr_data` into `mask_q` unchanged at the next edge; with no such write `mask_q` holds its value.
- R3: A control-register write with `cr_sel` = 0 clears every `pend_q` bit whose `cr_wr_data` bit is 1 and leaves the other bits unchanged; it never sets a bit.
- R4: With `wide_mode` = 1, an I/O write with index n (0 to 63) sets `pend_q` bit 63−n (bit 0 is the LSB) and changes no other bit.
- R5: With `wide_mode` = 0, an I/O write sets `pend_q` bit 31−k, where k is `io_wr_idx[4:0]`; `io_wr_idx[5]` is ignored, and no bit above 31 is ever set.
- R6: When an I/O write and a clearing control-register write hit the same pending bit in one cycle, the bit ends up set.
- R7: `irq` at each edge takes the value (OR of `pend_q & mask_q`) AND `int_enable` as they stood before that edge, so it follows any change of those by exactly one cycle.
- R8: A mask write leaves `pend_q` unchanged, and an I/O write leaves `mask_q` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_mode | input | 1 | 1: 6-bit source numbers over 64 bits; 0: 5-bit numbers over the lower 32 bits |
| int_enable | input | 1 | Global interrupt enable |
| cr_wr_en | input | 1 | Control-register write strobe |
| cr_sel | input | 1 | Target of the control-register write: 0 pending (clear by ones), 1 enable mask |
| cr_wr_data | input | 64 | Control-register write data |
| io_wr_en | input | 1 | Memory-mapped set strobe |
| io_wr_idx | input | 6 | Number of the source to set, counted from the MSB |
| pend_q | output | 64 | Pending register |
| mask_q | output | 64 | Enable mask register |
| irq | output | 1 | Registered interrupt request |

## Verification
A wrong number-to-bit mapping shows on `pend_q` at the first edge after the I/O write, as a 1 in a bit other than the named one. A wrong clear or priority rule shows on `pend_q` one edge after the control-register write, and a fault in the request path shows on `irq` one edge after the pending, mask or enable state changes. The sweeps name every source number in both width modes, so each mapping error shows up within one write.

// File: rtl/xint_pkg.sv
package xint_pkg;
  // Selects the target of a control-register write
  typedef enum logic {
    CR_TGT_PEND = 1'b0,
    CR_TGT_MASK = 1'b1
  } cr_tgt_e;

  // LSB-0 position named by an MSB-0 source number within a field of fld_w bits
  function automatic int unsigned msb0_to_pos(input int unsigned num, input int unsigned fld_w);
    return fld_w - 1 - num;
  endfunction
endpackage

// File: rtl/xint_bitsel.sv
module xint_bitsel #(
  parameter int NUM_SRC = 64,
  localparam int IDX_W  = $clog2(NUM_SRC),
  localparam int HALF   = NUM_SRC / 2
) (
  input  logic               valid,
  input  logic               wide_mode,
  input  logic [IDX_W-1:0]   idx,
  output logic [NUM_SRC-1:0] set_vec
);
  import xint_pkg::*;

  // One comparator per bit; each bit knows the source number that names it
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
    localparam logic [IDX_W-1:0] WIDE_CODE = IDX_W'(msb0_to_pos(g, NUM_SRC));
    logic wide_hit;
    logic narrow_hit;
    assign wide_hit = (idx == WIDE_CODE);
    if (g < HALF) begin : g_low
      localparam logic [IDX_W-2:0] NARROW_CODE = (IDX_W-1)'(msb0_to_pos(g, HALF));
      assign narrow_hit = (idx[IDX_W-2:0] == NARROW_CODE);
    end else begin : g_high
      assign narrow_hit = 1'b0;
    end
    assign set_vec[g] = valid & (wide_mode ? wide_hit : narrow_hit);
  end
endmodule

// File: rtl/xint_pend_reg.sv
module xint_pend_reg #(
  parameter int NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr_en,
  input  logic [NUM_SRC-1:0] clr_bits,
  input  logic [NUM_SRC-1:0] set_bits,
  output logic [NUM_SRC-1:0] pend_q
);
  logic [NUM_SRC-1:0] clr_vec;
  logic [NUM_SRC-1:0] pend_d;

  always_comb begin
    clr_vec = clr_en ? clr_bits : '0;
    // Set is applied after clear so a colliding set is never lost
    pend_d  = (pend_q & ~clr_vec) | set_bits;
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_d;
  end
endmodule

// File: rtl/xint_mask_reg.sv
module xint_mask_reg #(
  parameter int NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ld_en,
  input  logic [NUM_SRC-1:0] ld_data,
  output logic [NUM_SRC-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (rst)        mask_q <= '0;
    else if (ld_en) mask_q <= ld_data;
  end
endmodule

// File: rtl/xint_req_gen.sv
module xint_req_gen #(
  parameter int NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] pend,
  input  logic [NUM_SRC-1:0] mask,
  input  logic               glob_en,
  output logic               irq
);
  logic any_live;

  assign any_live = |(pend & mask);

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= any_live & glob_en;
  end
endmodule

// File: rtl/xint_pend_unit.sv
module xint_pend_unit #(
  parameter int NUM_SRC = 64,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wide_mode,
  input  logic               int_enable,
  input  logic               cr_wr_en,
  input  logic               cr_sel,
  input  logic [NUM_SRC-1:0] cr_wr_data,
  input  logic               io_wr_en,
  input  logic [IDX_W-1:0]   io_wr_idx,
  output logic [NUM_SRC-1:0] pend_q,
  output logic [NUM_SRC-1:0] mask_q,
  output logic               irq
);
  import xint_pkg::*;

  logic [NUM_SRC-1:0] set_vec;
  logic               pend_clr_en;
  logic               mask_ld_en;

  assign pend_clr_en = cr_wr_en & (cr_tgt_e'(cr_sel) == CR_TGT_PEND);
  assign mask_ld_en  = cr_wr_en & (cr_tgt_e'(cr_sel) == CR_TGT_MASK);

  xint_bitsel #(.NUM_SRC(NUM_SRC)) u_bitsel (
    .valid     (io_wr_en),
    .wide_mode (wide_mode),
    .idx       (io_wr_idx),
    .set_vec   (set_vec)
  );

  xint_pend_reg #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk      (clk),
    .rst      (rst),
    .clr_en   (pend_clr_en),
    .clr_bits (cr_wr_data),
    .set_bits (set_vec),
    .pend_q   (pend_q)
  );

  xint_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk     (clk),
    .rst     (rst),
    .ld_en   (mask_ld_en),
    .ld_data (cr_wr_data),
    .mask_q  (mask_q)
  );

  xint_req_gen #(.NUM_SRC(NUM_SRC)) u_req (
    .clk     (clk),
    .rst     (rst),
    .pend    (pend_q),
    .mask    (mask_q),
    .glob_en (int_enable),
    .irq     (irq)
  );
endmodule

// File: rtl/xint_pend_unit_chk.sv
module xint_pend_unit_chk #(
  parameter int NUM_SRC = 64,
  localparam int IDX_W  = $clog2(NUM_SRC),
  localparam int HALF   = NUM_SRC / 2
) (
  input logic               clk,
  input logic               rst,
  input logic               wide_mode,
  input logic               int_enable,
  input logic               cr_wr_en,
  input logic               cr_sel,
  input logic [NUM_SRC-1:0] cr_wr_data,
  input logic               io_wr_en,
  input logic [IDX_W-1:0]   io_wr_idx,
  input logic [NUM_SRC-1:0] pend_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic               irq
);
  logic [NUM_SRC-1:0] upper_half;
  assign upper_half = {{HALF{1'b1}}, {HALF{1'b0}}};

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (pend_q == '0 && mask_q == '0 && !irq));

  a_r2_mask_load: assert property (@(posedge clk) disable iff (rst)
    (cr_wr_en && cr_sel) |=> (mask_q == $past(cr_wr_data)));

  a_r2_mask_hold: assert property (@(posedge clk) disable iff (rst)
    !(cr_wr_en && cr_sel) |=> $stable(mask_q));

  a_r3_clear_only: assert property (@(posedge clk) disable iff (rst)
    (cr_wr_en && !cr_sel && !io_wr_en) |=> ((pend_q & ~$past(pend_q)) == '0));

  a_r4_single_set: assert property (@(posedge clk) disable iff (rst)
    (io_wr_en && !(cr_wr_en && !cr_sel)) |=> ($countones(pend_q ^ $past(pend_q)) <= 1));

  a_r5_narrow_low_half: assert property (@(posedge clk) disable iff (rst)
    (io_wr_en && !wide_mode && !(cr_wr_en && !cr_sel)) |=>
      ((pend_q & upper_half) == ($past(pend_q) & upper_half)));

  a_r6_set_survives: assert property (@(posedge clk) disable iff (rst)
    io_wr_en |=> (pend_q != '0));

  a_r7_irq_latency: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == ($past(|(pend_q & mask_q)) && $past(int_enable))));

  a_r8_pend_hold: assert property (@(posedge clk) disable iff (rst)
    (!io_wr_en && !(cr_wr_en && !cr_sel)) |=> $stable(pend_q));

  a_r8_idx_width: assert property (@(posedge clk) disable iff (rst)
    (io_wr_en && wide_mode && io_wr_idx == '0 && !(cr_wr_en && !cr_sel)) |=> pend_q[NUM_SRC-1]);
endmodule

bind xint_pend_unit xint_pend_unit_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wide_mode  (wide_mode),
  .int_enable (int_enable),
  .cr_wr_en   (cr_wr_en),
  .cr_sel     (cr_sel),
  .cr_wr_data (cr_wr_data),
  .io_wr_en   (io_wr_en),
  .io_wr_idx  (io_wr_idx),
  .pend_q     (pend_q),
  .mask_q     (mask_q),
  .irq        (irq)
);

// File: tb/xint_pend_unit_bench.sv
`timescale 1ns/1ps
module xint_pend_unit_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        wide_mode;
  logic        int_enable;
  logic        cr_wr_en;
  logic        cr_sel;
  logic [63:0] cr_wr_data;
  logic        io_wr_en;
  logic [5:0]  io_wr_idx;
  logic [63:0] pend_q;
  logic [63:0] mask_q;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [63:0] exp_pend;

  always #2 clk = ~clk;

  xint_pend_unit u_xint_pend_unit (
    .clk(clk), .rst(rst), .wide_mode(wide_mode), .int_enable(int_enable),
    .cr_wr_en(cr_wr_en), .cr_sel(cr_sel), .cr_wr_data(cr_wr_data),
    .io_wr_en(io_wr_en), .io_wr_idx(io_wr_idx),
    .pend_q(pend_q), .mask_q(mask_q), .irq(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // All drives start at a falling edge; the next falling edge follows one rising edge
  task automatic cycle();
    @(negedge clk);
    cr_wr_en = 1'b0;
    io_wr_en = 1'b0;
  endtask

  task automatic cr_write(input logic sel, input logic [63:0] data);
    cr_wr_en = 1'b1; cr_sel = sel; cr_wr_data = data;
    cycle();
  endtask

  task automatic io_write(input logic [5:0] idx);
    io_wr_en = 1'b1; io_wr_idx = idx;
    cycle();
  endtask

  initial begin
    rst = 1'b1; wide_mode = 1'b1; int_enable = 1'b0;
    cr_wr_en = 1'b0; cr_sel = 1'b0; cr_wr_data = '0;
    io_wr_en = 1'b0; io_wr_idx = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 pend after reset", pend_q, 64'd0);
    chk("R1 mask after reset", mask_q, 64'd0);
    chk("R1 irq after reset", {63'd0, irq}, 64'd0);

    // R2 / R8: mask loads as written, pending untouched
    cr_write(1'b1, 64'hA5A5_0F0F_1234_8001);
    chk("R2 mask load", mask_q, 64'hA5A5_0F0F_1234_8001);
    chk("R8 mask write leaves pend", pend_q, 64'd0);
    cycle();
    chk("R2 mask holds", mask_q, 64'hA5A5_0F0F_1234_8001);

    // R4: wide sweep, every source number
    exp_pend = '0;
    wide_mode = 1'b1;
    for (int n = 0; n < 64; n++) begin
      io_write(6'(n));
      exp_pend |= 64'd1 << (63 - n);
      chk($sformatf("R4 wide idx %0d", n), pend_q, exp_pend);
    end
    chk("R8 io write leaves mask", mask_q, 64'hA5A5_0F0F_1234_8001);

    // R3: clear by ones
    cr_write(1'b0, 64'hFFFF_0000_F0F0_0001);
    exp_pend &= ~64'hFFFF_0000_F0F0_0001;
    chk("R3 clear pattern", pend_q, exp_pend);
    cr_write(1'b0, 64'd0);
    chk("R3 zero data clears nothing", pend_q, exp_pend);
    cr_write(1'b0, '1);
    exp_pend = '0;
    chk("R3 clear all", pend_q, exp_pend);

    // R5: narrow sweep including the ignored top index bit
    wide_mode = 1'b0;
    for (int n = 0; n < 64; n++) begin
      io_write(6'(n));
      exp_pend |= 64'd1 << (31 - (n % 32));
      chk($sformatf("R5 narrow idx %0d", n), pend_q, exp_pend);
    end

    // R6: set and clear on the same bit, wide and narrow
    cr_wr_en = 1'b1; cr_sel = 1'b0; cr_wr_data = '1;
    io_write(6'd7);
    chk("R6 narrow set wins", pend_q, 64'd1 << 24);
    wide_mode = 1'b1;
    cr_wr_en = 1'b1; cr_sel = 1'b0; cr_wr_data = '1;
    io_write(6'd2);
    chk("R6 wide set wins", pend_q, 64'd1 << 61);

    // R7: request latency
    cr_write(1'b1, 64'd0);
    int_enable = 1'b1;
    cycle();
    chk("R7 masked no irq", {63'd0, irq}, 64'd0);
    cr_write(1'b1, 64'd1 << 61);
    chk("R7 irq not yet", {63'd0, irq}, 64'd0);
    cycle();
    chk("R7 irq one cycle later", {63'd0, irq}, 64'd1);
    int_enable = 1'b0;
    cycle();
    chk("R7 global enable drop", {63'd0, irq}, 64'd0);
    int_enable = 1'b1;
    cycle();
    chk("R7 global enable back", {63'd0, irq}, 64'd1);
    cr_write(1'b0, 64'd1 << 61);
    chk("R7 irq holds one cycle after clear", {63'd0, irq}, 64'd1);
    cycle();
    chk("R7 irq drops after clear", {63'd0, irq}, 64'd0);

    // R1: reset mid-run
    io_write(6'd0);
    rst = 1'b1;
    cycle();
    rst = 1'b0;
    chk("R1 pend after late reset", pend_q, 64'd0);
    chk("R1 mask after late reset", mask_q, 64'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule